// File: doc/BRIEF.md
# Page-Confined Stride Stream Prefetcher

This block watches the demand-load stream of a core, one cache-line address per cycle, and turns it into prefetch requests. It keeps one stream record for each 4 KiB page it has seen recently. The first load into a page only claims a record. Every later load into that page measures a signed stride in lines from the previous load to the same page. It then proposes the next two lines along that stride. Any proposal that would leave the page is discarded.

Accepted proposals go into a short request queue, and the prefetch port drains that queue with a valid/ready handshake. Demand loads are never stalled. When the queue has no room, proposals are simply lost. Each stream also remembers the last line it queued, so a proposal equal to that line is not issued a second time.

Top module: `page_stride_prefetcher`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, pf_valid_o is 0, and every stream record is empty.
- R2: A load to a page with no stream record claims a record and produces no prefetch. Here the page is ld_line_i[LINE_W-1:6], and the line index within the page is ld_line_i[5:0].
- R3: A load to a tracked page with line index i, whose previous load had index p, has stride s = i - p. When s is not 0, it proposes i+s first and then i+2s, both within the same page. A queued proposal shows at pf_valid_o/pf_line_o starting in the cycle after the load, provided the queue was empty.
- R4: A proposed index below 0 or above 63 is dropped, so pf_line_o never leaves the page of the load that produced it.
- R5: A load that repeats the previous line of its page (s = 0) issues no prefetch. It still makes that page the most recently used.
- R6: A proposal equal to the last line its stream put in the queue is suppressed and takes no queue slot.
- R7: At most 32 pages are tracked. A load to a new page when all 32 are in use replaces the least recently used page. A later load to the replaced page counts as a first access (R2).
- R8: The queue holds 4 requests. The room for one load's proposals is 4 minus the occupancy at the start of that cycle, and proposals beyond that room are dropped in order. A dropped proposal does not change the stream's last-queued line.
- R9: Requests leave the queue in the order they entered it. While pf_valid_o is 1 and pf_ready_i is 0, pf_valid_o stays 1 and pf_line_o holds its value.
- R10: The stride always comes from the two most recent loads to the page, so a changed spacing takes effect on the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | A demand load is presented this cycle |
| ld_line_i | input | LINE_W (34) | Cache-line address of the load |
| pf_ready_i | input | 1 | The prefetch port takes the head request |
| pf_valid_o | output | 1 | A prefetch request is waiting |
| pf_line_o | output | LINE_W (34) | Cache-line address to prefetch |

## Verification
Several properties are checked on every cycle: that the queue never exceeds 4 entries or takes more than its free room, that at most one record matches a page, that a zero stride queues nothing, that a held request stays put, and that a request appears only right after a load. Other behaviour can only be shown by a reference model run alongside the bench's scenarios. That includes the stride arithmetic, the page clipping at both edges, duplicate suppression, the order of least-recently-used replacement, and which proposals survive a full queue.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned DEF_LINE_W  = 34;
  localparam int unsigned DEF_IDX_W   = 6;   // 64 B lines in a 4 KiB page
  localparam int unsigned DEF_STREAMS = 32;
  localparam int unsigned DEF_DEPTH   = 4;
  localparam int unsigned DEF_AHEAD   = 2;
endpackage

// File: rtl/pfs_stream_table.sv
module pfs_stream_table #(
  parameter int unsigned TAG_W = 28,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned N     = 32,
  localparam int unsigned AW   = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic             lpf_set_i,
  input  logic [IDX_W-1:0] lpf_idx_i,
  output logic             hit_o,
  output logic [N-1:0]     hit_vec_o,
  output logic [IDX_W-1:0] prev_idx_o,
  output logic             lpf_vld_o,
  output logic [IDX_W-1:0] lpf_idx_o
);
  logic [N-1:0]     vld_q, lpfv_q;
  logic [TAG_W-1:0] tag_q  [N];
  logic [IDX_W-1:0] last_q [N];
  logic [IDX_W-1:0] lpf_q  [N];
  logic [AW-1:0]    age_q  [N];

  logic [N-1:0]  vic_vec, touch_vec;
  logic [AW-1:0] touch_age;

  always_comb begin
    for (int i = 0; i < N; i++) hit_vec_o[i] = vld_q[i] && (tag_q[i] == lk_tag_i);
  end
  assign hit_o = |hit_vec_o;

  always_comb begin
    prev_idx_o = '0;
    lpf_vld_o  = 1'b0;
    lpf_idx_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) begin
        prev_idx_o = prev_idx_o | last_q[i];
        lpf_vld_o  = lpf_vld_o | lpfv_q[i];
        lpf_idx_o  = lpf_idx_o | lpf_q[i];
      end
    end
  end

  // victim: lowest free slot, else the oldest
  always_comb begin
    logic found;
    found   = 1'b0;
    vic_vec = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld_q[i] && !found) begin
        vic_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) vic_vec[i] = (age_q[i] == AW'(N-1));
    end
  end

  assign touch_vec = hit_o ? hit_vec_o : vic_vec;

  always_comb begin
    touch_age = '0;
    for (int i = 0; i < N; i++) if (touch_vec[i]) touch_age = touch_age | age_q[i];
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        lpfv_q[g] <= 1'b0;
        age_q[g]  <= AW'(g);
      end else if (lk_valid_i) begin
        if (touch_vec[g]) begin
          vld_q[g]  <= 1'b1;
          age_q[g]  <= '0;
          if (!hit_o)         lpfv_q[g] <= 1'b0;
          else if (lpf_set_i) lpfv_q[g] <= 1'b1;
        end else if (age_q[g] < touch_age) begin
          age_q[g] <= age_q[g] + AW'(1);
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (lk_valid_i && touch_vec[g]) begin
        tag_q[g]  <= lk_tag_i;
        last_q[g] <= lk_idx_i;
        if (hit_o && lpf_set_i) lpf_q[g] <= lpf_idx_i;
      end
    end
  end
endmodule

// File: rtl/pfs_cand_gen.sv
module pfs_cand_gen #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned AHEAD = 2,
  localparam int unsigned SW   = IDX_W + $clog2(AHEAD) + 3
) (
  input  logic             hit_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic [IDX_W-1:0] prev_idx_i,
  input  logic             lpf_vld_i,
  input  logic [IDX_W-1:0] lpf_idx_i,
  output logic [AHEAD-1:0] cand_vld_o,
  output logic [IDX_W-1:0] cand_idx_o [AHEAD]
);
  logic signed [SW-1:0] cur_s, stride;

  assign cur_s  = $signed({{(SW-IDX_W){1'b0}}, cur_idx_i});
  assign stride = cur_s - $signed({{(SW-IDX_W){1'b0}}, prev_idx_i});

  for (genvar k = 0; k < AHEAD; k++) begin : g_ahead
    logic signed [SW-1:0] tgt;
    logic                 in_page, dup;
    assign tgt           = cur_s + $signed(SW'(k + 1)) * stride;
    assign in_page       = (tgt[SW-1:IDX_W] == '0);
    assign dup           = lpf_vld_i && (tgt[IDX_W-1:0] == lpf_idx_i);
    assign cand_idx_o[k] = tgt[IDX_W-1:0];
    assign cand_vld_o[k] = hit_i && (stride != '0) && in_page && !dup;
  end
endmodule

// File: rtl/pfs_req_fifo.sv
module pfs_req_fifo #(
  parameter int unsigned W     = 34,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned NW    = 2,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned NCW  = $clog2(NW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCW-1:0] push_n_i,
  input  logic [W-1:0]   push_data_i [NW],
  input  logic           pop_i,
  output logic [CW-1:0]  count_o,
  output logic [W-1:0]   head_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + PW'(push_n_i);
      if (pop_i) rd_q <= rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_n_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < NW; k++) begin
      if (NCW'(k) < push_n_i) mem_q[wr_q + PW'(k)] <= push_data_i[k];
    end
  end

  assign count_o = cnt_q;
  assign head_o  = mem_q[rd_q];
endmodule

// File: rtl/page_stride_prefetcher.sv
module page_stride_prefetcher
  import pfs_pkg::*;
#(
  parameter int unsigned LINE_W  = DEF_LINE_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned STREAMS = DEF_STREAMS,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  parameter int unsigned AHEAD   = DEF_AHEAD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [LINE_W-1:0] ld_line_i,
  input  logic              pf_ready_i,
  output logic              pf_valid_o,
  output logic [LINE_W-1:0] pf_line_o
);
  localparam int unsigned TAG_W = LINE_W - IDX_W;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned NCW   = $clog2(AHEAD + 1);

  logic [TAG_W-1:0]   ld_tag;
  logic [IDX_W-1:0]   ld_idx, prev_idx, lpf_idx, set_idx;
  logic               tbl_hit, lpf_vld, set_lpf, zero_stride, pop;
  logic [STREAMS-1:0] hit_vec;
  logic [AHEAD-1:0]   cand_vld;
  logic [IDX_W-1:0]   cand_idx [AHEAD];
  logic [LINE_W-1:0]  enq_data [AHEAD];
  logic [NCW-1:0]     enq_n;
  logic [CW-1:0]      fifo_cnt;

  assign ld_tag      = ld_line_i[LINE_W-1:IDX_W];
  assign ld_idx      = ld_line_i[IDX_W-1:0];
  assign zero_stride = tbl_hit && (prev_idx == ld_idx);

  pfs_stream_table #(.TAG_W(TAG_W), .IDX_W(IDX_W), .N(STREAMS)) u_tbl (
    .clk_i, .rst_ni,
    .lk_valid_i (ld_valid_i),
    .lk_tag_i   (ld_tag),
    .lk_idx_i   (ld_idx),
    .lpf_set_i  (set_lpf),
    .lpf_idx_i  (set_idx),
    .hit_o      (tbl_hit),
    .hit_vec_o  (hit_vec),
    .prev_idx_o (prev_idx),
    .lpf_vld_o  (lpf_vld),
    .lpf_idx_o  (lpf_idx)
  );

  pfs_cand_gen #(.IDX_W(IDX_W), .AHEAD(AHEAD)) u_cand (
    .hit_i      (ld_valid_i && tbl_hit),
    .cur_idx_i  (ld_idx),
    .prev_idx_i (prev_idx),
    .lpf_vld_i  (lpf_vld),
    .lpf_idx_i  (lpf_idx),
    .cand_vld_o (cand_vld),
    .cand_idx_o (cand_idx)
  );

  // compact surviving candidates in order, limited by free room
  always_comb begin
    int n;
    int room;
    n    = 0;
    room = int'(DEPTH) - int'(fifo_cnt);
    set_idx = '0;
    for (int k = 0; k < AHEAD; k++) enq_data[k] = '0;
    for (int k = 0; k < AHEAD; k++) begin
      if (cand_vld[k] && n < room) begin
        enq_data[n] = {ld_tag, cand_idx[k]};
        set_idx     = cand_idx[k];
        n           = n + 1;
      end
    end
    enq_n   = NCW'(n);
    set_lpf = (n != 0);
  end

  assign pf_valid_o = (fifo_cnt != '0);
  assign pop        = pf_valid_o && pf_ready_i;

  pfs_req_fifo #(.W(LINE_W), .DEPTH(DEPTH), .NW(AHEAD)) u_fifo (
    .clk_i, .rst_ni,
    .push_n_i    (enq_n),
    .push_data_i (enq_data),
    .pop_i       (pop),
    .count_o     (fifo_cnt),
    .head_o      (pf_line_o)
  );
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int unsigned LINE_W  = 34,
  parameter int unsigned STREAMS = 32,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned CW      = 3,
  parameter int unsigned NCW     = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ld_valid_i,
  input logic               pf_ready_i,
  input logic               pf_valid_o,
  input logic [LINE_W-1:0]  pf_line_o,
  input logic [CW-1:0]      fifo_cnt,
  input logic [NCW-1:0]     enq_n,
  input logic [STREAMS-1:0] hit_vec,
  input logic               zero_stride
);
  p_reset_quiet_r1: assert property (@(posedge clk_i) !rst_ni |-> !pf_valid_o);

  p_origin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_valid_o) |-> $past(ld_valid_i));

  p_zero_stride_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && zero_stride) |-> (enq_n == '0));

  p_one_page_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_fifo_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fifo_cnt) <= int'(DEPTH));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(enq_n) <= int'(DEPTH) - int'(fifo_cnt));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_line_o)));
endmodule

bind page_stride_prefetcher pfs_checker #(
  .LINE_W(LINE_W), .STREAMS(STREAMS), .DEPTH(DEPTH), .CW(CW), .NCW(NCW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_valid_i  (ld_valid_i),
  .pf_ready_i  (pf_ready_i),
  .pf_valid_o  (pf_valid_o),
  .pf_line_o   (pf_line_o),
  .fifo_cnt    (fifo_cnt),
  .enq_n       (enq_n),
  .hit_vec     (hit_vec),
  .zero_stride (zero_stride)
);

// File: tb/sim_page_stride_prefetcher.sv
`timescale 1ns/1ps
module sim_page_stride_prefetcher;
  localparam int LW = 34;
  localparam int IW = 6;
  localparam int NS = 32;
  localparam int FD = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_valid_i = 1'b0;
  logic [LW-1:0] ld_line_i = '0;
  logic          pf_ready_i = 1'b0;
  logic          pf_valid_o;
  logic [LW-1:0] pf_line_o;

  always #10 clk_i = ~clk_i;

  page_stride_prefetcher u0 (.*);

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string req = "R1";

  typedef struct { int tag; int last; bit lpfv; int lpf; } ent_t;
  ent_t          tbl[$];
  logic [LW-1:0] mq[$];

  function automatic logic [LW-1:0] mkline(int tag, int idx);
    return {(LW-IW)'(tag), IW'(idx)};
  endfunction

  task automatic cmp();
    bit exp_v;
    logic [LW-1:0] exp_l;
    exp_v = (mq.size() > 0);
    exp_l = exp_v ? mq[0] : '0;
    checks++;
    if (pf_valid_o !== exp_v || (exp_v && pf_line_o !== exp_l)) begin
      errors++;
      $display("FAIL %s: valid=%0b line=%h expected valid=%0b line=%h",
               req, pf_valid_o, pf_line_o, exp_v, exp_l);
    end
  endtask

  // behavioural reference: recency list (front = newest) and a request queue
  task automatic model(bit v, int tag, int idx, bit rdy);
    int free;
    bit pop;
    int pos;
    logic [LW-1:0] add[$];
    free = FD - mq.size();
    pop  = (mq.size() > 0) && rdy;
    if (v) begin
      pos = -1;
      for (int i = 0; i < tbl.size(); i++) if (tbl[i].tag == tag) pos = i;
      if (pos >= 0) begin
        ent_t e;
        bit   ov;
        int   ol;
        int   s;
        e  = tbl[pos];
        tbl.delete(pos);
        ov = e.lpfv;
        ol = e.lpf;
        s  = idx - e.last;
        if (s != 0) begin
          for (int k = 1; k <= 2; k++) begin
            int t;
            t = idx + k * s;
            if (t >= 0 && t < 64 && !(ov && t == ol) && free > 0) begin
              add.push_back(mkline(tag, t));
              free--;
              e.lpf  = t;
              e.lpfv = 1'b1;
            end
          end
        end
        e.last = idx;
        tbl.push_front(e);
      end else begin
        ent_t n;
        n = '{tag, idx, 1'b0, 0};
        if (tbl.size() == NS) void'(tbl.pop_back());
        tbl.push_front(n);
      end
    end
    if (pop) void'(mq.pop_front());
    foreach (add[i]) mq.push_back(add[i]);
  endtask

  task automatic step(bit v, int tag, int idx, bit rdy);
    @(negedge clk_i);
    cmp();
    model(v, tag, idx, rdy);
    ld_valid_i = v;
    ld_line_i  = mkline(tag, idx);
    pf_ready_i = rdy;
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, rdy);
  endtask

  task automatic expect_line(string r, logic [LW-1:0] exp);
    @(negedge clk_i);
    checks++;
    if (pf_valid_o !== 1'b1 || pf_line_o !== exp) begin
      errors++;
      $display("FAIL %s: valid=%0b line=%h expected valid=1 line=%h", r, pf_valid_o, pf_line_o, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset
    repeat (3) @(negedge clk_i);
    checks++;
    if (pf_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b expected 0", pf_valid_o);
    end
    rst_ni = 1'b1;
    idle(2, 1'b1);

    // R2/R3: first touch then stride 2, watched in the issue cycle
    req = "R2"; step(1'b1, 5, 10, 1'b1);
    req = "R3"; step(1'b1, 5, 12, 1'b0);
    step(1'b0, 0, 0, 1'b0);
    expect_line("R3", mkline(5, 14));
    ld_valid_i = 1'b0;
    idle(1, 1'b1);
    idle(3, 1'b1);

    // R10: spacing change
    req = "R10"; step(1'b1, 5, 20, 1'b1); idle(4, 1'b1);

    // R4: page edges, both directions
    req = "R4";
    step(1'b1, 6, 50, 1'b1); step(1'b1, 6, 58, 1'b1); idle(3, 1'b1);
    step(1'b1, 7, 60, 1'b1); step(1'b1, 7, 62, 1'b1); idle(3, 1'b1);
    step(1'b1, 8, 5, 1'b1);  step(1'b1, 8, 3, 1'b1);  idle(3, 1'b1);
    step(1'b1, 9, 63, 1'b1); step(1'b1, 9, 0, 1'b1);  idle(3, 1'b1);

    // R5: repeated line
    req = "R5"; step(1'b1, 8, 3, 1'b1); step(1'b1, 8, 3, 1'b1); idle(3, 1'b1);

    // R6: duplicate of last queued line
    req = "R6";
    step(1'b1, 10, 0, 1'b1); step(1'b1, 10, 1, 1'b1);
    step(1'b1, 10, 2, 1'b1); idle(4, 1'b1);
    step(1'b1, 10, 0, 1'b1); step(1'b1, 10, 2, 1'b1); idle(4, 1'b1);

    // R8/R9: back-pressure, drops on full, ordered drain
    req = "R8";
    step(1'b1, 11, 0, 1'b0); step(1'b1, 11, 4, 1'b0);
    step(1'b1, 11, 16, 1'b0); step(1'b1, 11, 28, 1'b0);
    req = "R9"; idle(3, 1'b0);
    req = "R8"; idle(6, 1'b1);
    step(1'b1, 11, 32, 1'b1); idle(4, 1'b1);

    // R7: capacity and LRU replacement
    req = "R7";
    for (int p = 100; p < 132; p++) step(1'b1, p, 1, 1'b1);
    step(1'b1, 100, 2, 1'b1);
    step(1'b1, 132, 1, 1'b1);
    step(1'b1, 101, 5, 1'b1);
    step(1'b1, 100, 4, 1'b1);
    step(1'b1, 102, 3, 1'b1);
    step(1'b1, 103, 9, 1'b1);
    idle(5, 1'b1);

    // mixed traffic
    req = "R3/R4/R6/R7/R8/R9";
    for (int i = 0; i < 4000; i++) begin
      bit v;
      v = ($urandom_range(0, 3) != 0);
      step(v, 200 + $urandom_range(0, 39), $urandom_range(0, 63), $urandom_range(0, 3) != 0);
    end
    req = "R9"; idle(8, 1'b1);

    checks++;
    if (pf_valid_o !== 1'b0 || mq.size() != 0) begin
      errors++;
      $display("FAIL R9: valid=%0b expected 0 after drain", pf_valid_o);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule